// File: doc/BRIEF.md
# Continuous-select SPI master

This block is an SPI master that moves data frames from a transmit FIFO onto the serial line and collects the received frames into a receive FIFO. A command word, written through a single-cycle strobe, chooses which of the four active-low selects to drive. It also sets the frame length, and two flags decide whether the select stays low across frames. The serial clock runs at a quarter of the system clock. It idles high, MOSI changes on the falling edge, and MISO is sampled on the rising edge, most significant bit first.

With the continuous flag set, frames run back to back under one select pulse for as long as transmit data is waiting. When the transmit FIFO runs dry, the master parks partway through the last bit of the burst. The clock stays low, the select stays low, and the unfinished frame is kept out of the receive FIFO. What happens next is decided by the next event:
- More transmit data lets the burst carry on under the same select.
- A terminating command finishes the bit, stores the frame and releases the select.
- A continuing command changes nothing.

Software can therefore split one selected transaction into several separately issued transfers.

Top module: `spim_top`

## Requirements
- R1: After reset all four select outputs are high, the serial clock is high, busy is low, and both FIFOs report empty and not full.
- R2: Each half period of the serial clock lasts two system clocks. MOSI changes only while the clock is low or at its falling edge. MISO is captured on the rising edge, and bits go out most significant first.
- R3: With the continuous flag clear, every frame gets its own select pulse, so N frames give N pulses.
- R4: With the continuous flag set and transmit data available, consecutive frames share one select pulse. A 20-frame burst yields exactly 20 receive entries once it is terminated.
- R5: In continuous mode with the transmit FIFO empty at the last bit of a frame, the clock is held low mid-bit with the select low and busy high, and that frame is not pushed into the receive FIFO.
- R6: While held, a command with both the continuous and continuing flags set leaves the clock, the select and the receive FIFO unchanged.
- R7: While held, a command with the continuing flag clear, or with the continuous flag clear, produces the final rising edge and pushes the frame. The select then rises, and it rises only with the clock high.
- R8: While held with the continuous flag still set, new transmit data completes the held edge, pushes the frame and runs the next frame without raising the select.
- R9: If a terminating command and a transmit push land in the same cycle while held, the held sequence is terminated first. The new word then goes out under a fresh select pulse using the new command's select index.
- R10: The 2-bit select index in the command picks one select output. Only that output goes low, and it does not change during a pulse.
- R11: The length field holds the frame length minus one (1 to 8 bits). Transmit data is taken from the low bits of the word, and received frames are right-aligned with the upper bits zero.
- R12: When the receive FIFO is full, the master stalls before the final rising edge of a frame and never overruns. It resumes once an entry is popped.
- R13: Busy is high exactly while a select output is low, including the held state.
- R14: Both FIFOs hold 4 entries. The full flag rises when 4 words are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | One-cycle command write strobe |
| cmd_cs_i | input | 2 | Select index for the command |
| cmd_cont_i | input | 1 | Keep select asserted between frames |
| cmd_contc_i | input | 1 | Command continues the running sequence |
| cmd_len_i | input | 3 | Frame length minus one |
| tx_push_i | input | 1 | Push one word into the transmit FIFO |
| tx_data_i | input | 8 | Transmit word |
| tx_full_o | output | 1 | Transmit FIFO full |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| rx_pop_i | input | 1 | Pop the receive FIFO head |
| rx_data_o | output | 8 | Receive FIFO head |
| rx_full_o | output | 1 | Receive FIFO full |
| rx_empty_o | output | 1 | Receive FIFO empty |
| sck_o | output | 1 | Serial clock, idle high |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 4 | Active-low selects |
| busy_o | output | 1 | A select is asserted |

## Verification
The release of a held sequence and the start of a new transfer can fall in the same cycle. The bench provokes this by parking a continuous burst, then raising a terminating command and a transmit push on the same clock edge. The outcome is judged at the pins. The held frame must reach the receive scoreboard first, and busy must fall once. A second select pulse must then appear on the new command's select index, carrying the new word.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } spim_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wr_q, rd_q;
  logic          do_wr, do_rd;

  assign full_o  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign empty_o = (wr_q == rd_q);
  assign do_wr   = push_i && !full_o;
  assign do_rd   = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wr_q[AW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_wr) wr_q <= wr_q + 1'b1;
      if (do_rd) rd_q <= rd_q + 1'b1;
    end
  end
endmodule

// File: rtl/spim_halfcnt.sv
module spim_halfcnt #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic done_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(HALF - 1));

  // saturates at done so a stalled phase can act later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (!done_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spim_csdec.sv
module spim_csdec #(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic              sel_i,
  input  logic [CS_W-1:0]   idx_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n_o[g] = !(sel_i && (idx_i == CS_W'(g)));
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CS_W   = 2,
  parameter int LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CS_W-1:0]   cmd_cs_i,
  input  logic              cmd_cont_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic              term_pend_i,
  input  logic              half_done_i,
  input  logic              tx_empty_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  input  logic              rx_full_i,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              sel_o,
  output logic [CS_W-1:0]   sel_idx_o,
  output logic              restart_o,
  output logic              release_o
);
  spim_state_e       state_q, state_d;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic [LEN_W-1:0]  bit_q;
  logic [CS_W-1:0]   cs_q;
  logic              last, keep_sel, park;
  logic              load, shift_in, step;

  assign last     = (bit_q == '0);
  assign keep_sel = cmd_cont_i && !term_pend_i;
  // withhold the final rising edge: burst parked, or no room for the frame
  assign park     = last && ((keep_sel && tx_empty_i) || rx_full_i);

  always_comb begin
    state_d   = state_q;
    tx_pop_o  = 1'b0;
    rx_push_o = 1'b0;
    restart_o = 1'b0;
    release_o = 1'b0;
    load      = 1'b0;
    shift_in  = 1'b0;
    step      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (!tx_empty_i) begin
        tx_pop_o  = 1'b1;
        load      = 1'b1;
        restart_o = 1'b1;
        state_d   = ST_SETUP;
      end
      ST_SETUP: if (half_done_i) begin
        restart_o = 1'b1;
        state_d   = ST_LOW;
      end
      ST_LOW: if (half_done_i && !park) begin
        restart_o = 1'b1;
        shift_in  = 1'b1;
        rx_push_o = last;
        state_d   = ST_HIGH;
      end
      ST_HIGH: if (half_done_i) begin
        restart_o = 1'b1;
        if (!last) begin
          step    = 1'b1;
          state_d = ST_LOW;
        end else if (keep_sel && !tx_empty_i) begin
          tx_pop_o = 1'b1;
          load     = 1'b1;
          state_d  = ST_LOW;
        end else begin
          release_o = 1'b1;
          state_d   = ST_GAP;
        end
      end
      ST_GAP: if (half_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      bit_q   <= '0;
      cs_q    <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        tx_sh_q <= tx_data_i;
        rx_sh_q <= '0;
        bit_q   <= cmd_len_i;
      end
      if (load && (state_q == ST_IDLE)) cs_q <= cmd_cs_i;
      if (shift_in) rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
      if (step)     bit_q   <= bit_q - 1'b1;
    end
  end

  assign rx_data_o = {rx_sh_q[DATA_W-2:0], miso_i};
  assign sck_o     = (state_q != ST_LOW);
  assign mosi_o    = tx_sh_q[bit_q];
  assign sel_o     = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign sel_idx_o = cs_q;
endmodule

// File: rtl/spim_top.sv
module spim_top #(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int NUM_CS     = 4,
  parameter int SCK_DIV    = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  input  logic [$clog2(NUM_CS)-1:0]  cmd_cs_i,
  input  logic                       cmd_cont_i,
  input  logic                       cmd_contc_i,
  input  logic [$clog2(DATA_W)-1:0]  cmd_len_i,
  input  logic                       tx_push_i,
  input  logic [DATA_W-1:0]          tx_data_i,
  output logic                       tx_full_o,
  output logic                       tx_empty_o,
  input  logic                       rx_pop_i,
  output logic [DATA_W-1:0]          rx_data_o,
  output logic                       rx_full_o,
  output logic                       rx_empty_o,
  output logic                       sck_o,
  output logic                       mosi_o,
  input  logic                       miso_i,
  output logic [NUM_CS-1:0]          cs_n_o,
  output logic                       busy_o
);
  localparam int CS_W  = $clog2(NUM_CS);
  localparam int LEN_W = $clog2(DATA_W);
  localparam int HALF  = SCK_DIV / 2;

  logic [CS_W-1:0]   cmd_cs_q;
  logic              cmd_cont_q;
  logic [LEN_W-1:0]  cmd_len_q;
  logic              term_q;
  logic              tx_pop, rx_push, half_done, restart, release_sel;
  logic [DATA_W-1:0] tx_word, rx_word;
  logic [CS_W-1:0]   sel_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_cs_q   <= '0;
      cmd_cont_q <= 1'b0;
      cmd_len_q  <= LEN_W'(DATA_W - 1);
    end else if (cmd_valid_i) begin
      cmd_cs_q   <= cmd_cs_i;
      cmd_cont_q <= cmd_cont_i;
      cmd_len_q  <= cmd_len_i;
    end
  end

  // a non-continuing command seen while selected ends the sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          term_q <= 1'b0;
    else if (release_sel) term_q <= 1'b0;
    else if (cmd_valid_i && busy_o && !(cmd_cont_i && cmd_contc_i)) term_q <= 1'b1;
  end

  spim_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk_i, .rst_ni,
    .push_i (tx_push_i),
    .data_i (tx_data_i),
    .pop_i  (tx_pop),
    .data_o (tx_word),
    .full_o (tx_full_o),
    .empty_o(tx_empty_o)
  );

  spim_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk_i, .rst_ni,
    .push_i (rx_push),
    .data_i (rx_word),
    .pop_i  (rx_pop_i),
    .data_o (rx_data_o),
    .full_o (rx_full_o),
    .empty_o(rx_empty_o)
  );

  spim_halfcnt #(.HALF(HALF)) u_half (
    .clk_i, .rst_ni,
    .restart_i(restart),
    .done_o   (half_done)
  );

  spim_engine #(.DATA_W(DATA_W), .CS_W(CS_W), .LEN_W(LEN_W)) u_eng (
    .clk_i, .rst_ni,
    .cmd_cs_i   (cmd_cs_q),
    .cmd_cont_i (cmd_cont_q),
    .cmd_len_i  (cmd_len_q),
    .term_pend_i(term_q),
    .half_done_i(half_done),
    .tx_empty_i (tx_empty_o),
    .tx_data_i  (tx_word),
    .tx_pop_o   (tx_pop),
    .rx_full_i  (rx_full_o),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_word),
    .miso_i     (miso_i),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o),
    .sel_o      (busy_o),
    .sel_idx_o  (sel_idx),
    .restart_o  (restart),
    .release_o  (release_sel)
  );

  spim_csdec #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_dec (
    .sel_i (busy_o),
    .idx_i (sel_idx),
    .cs_n_o(cs_n_o)
  );
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int NUM_CS  = 4,
  parameter int SCK_DIV = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sck_i,
  input logic              mosi_i,
  input logic [NUM_CS-1:0] cs_n_i,
  input logic              busy_i,
  input logic              rx_full_i,
  input logic              rx_push_i
);
  localparam int HALF = SCK_DIV / 2;
  localparam int CW   = $clog2(HALF) + 1;

  logic          sck_d;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d <= 1'b1;
      run_q <= '0;
    end else begin
      sck_d <= sck_i;
      if (sck_i != sck_d)               run_q <= '0;
      else if (run_q < CW'(HALF - 1))   run_q <= run_q + 1'b1;
    end
  end

  // R2
  sck_half_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_i != sck_d) |-> (run_q >= CW'(HALF - 1)));

  // R2
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_i && $past(sck_i) && busy_i && $past(busy_i)) |-> $stable(mosi_i));

  // R5
  sck_low_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_i |-> busy_i);

  // R7
  release_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (sck_i && $past(sck_i)));

  // R10
  one_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_i));

  // R13
  busy_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> ($countones(~cs_n_i) == 1));

  // R10
  sel_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(cs_n_i));

  // R12
  no_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_i |-> !rx_push_i);
endmodule

bind spim_top spim_chk #(.NUM_CS(NUM_CS), .SCK_DIV(SCK_DIV)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sck_i    (sck_o),
  .mosi_i   (mosi_o),
  .cs_n_i   (cs_n_o),
  .busy_i   (busy_o),
  .rx_full_i(rx_full_o),
  .rx_push_i(rx_push)
);

// File: tb/sim_spim_top.sv
`timescale 1ns/1ps
module sim_spim_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_cont = 1'b0, cmd_contc = 1'b0;
  logic [1:0] cmd_cs = '0;
  logic [2:0] cmd_len = 3'd7;
  logic       tx_push = 1'b0, rx_pop = 1'b0, miso = 1'b0;
  logic [7:0] tx_data = '0, rx_data;
  logic       tx_full, tx_empty, rx_full, rx_empty, sck, mosi, busy;
  logic [3:0] cs_n;

  always #2 clk = ~clk;

  spim_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_cs_i(cmd_cs), .cmd_cont_i(cmd_cont),
    .cmd_contc_i(cmd_contc), .cmd_len_i(cmd_len),
    .tx_push_i(tx_push), .tx_data_i(tx_data), .tx_full_o(tx_full), .tx_empty_o(tx_empty),
    .rx_pop_i(rx_pop), .rx_data_o(rx_data), .rx_full_o(rx_full), .rx_empty_o(rx_empty),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n), .busy_o(busy)
  );

  int n_cmp = 0, n_bad = 0;
  int pulses = 0, rx_got = 0, slv_len = 8, slv_bit = 0, slv_fr = 0;
  bit auto_pop = 1'b1;
  logic [7:0] tx_q[$], rx_q[$];
  logic [7:0] slv_word = '0, slv_in = '0;

  function automatic logic [7:0] msk(int n);
    return 8'((1 << n) - 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // select pulse counter and slave frame reset
  always @(posedge busy) begin
    pulses++;
    slv_bit = 0;
  end

  // slave model: drive on falling edge, capture on rising edge
  always @(negedge sck) if (busy === 1'b1) begin
    if (slv_bit == 0) begin
      slv_word = 8'(8'h5A + 37 * slv_fr) & msk(slv_len);
      slv_fr++;
    end
    miso = slv_word[slv_len - 1 - slv_bit];
  end

  always @(posedge sck) if (busy === 1'b1 && rst_n) begin
    slv_in = {slv_in[6:0], mosi};
    slv_bit++;
    if (slv_bit == slv_len) begin
      if (tx_q.size() == 0) chk(1'b0, "R2 unexpected frame", 32'(slv_in), 0);
      else begin
        logic [7:0] e;
        e = tx_q.pop_front();
        chk((slv_in & msk(slv_len)) == e, "R2/R11 mosi frame", 32'(slv_in & msk(slv_len)), 32'(e));
      end
      rx_q.push_back(slv_word);
      slv_bit = 0;
    end
  end

  // monitor: pop and compare rx words
  always @(negedge clk) begin
    rx_pop = 1'b0;
    if (rst_n && auto_pop && !rx_empty) begin
      rx_pop = 1'b1;
      rx_got++;
      if (rx_q.size() == 0) chk(1'b0, "R4 unexpected rx word", 32'(rx_data), 0);
      else begin
        logic [7:0] e;
        e = rx_q.pop_front();
        chk(rx_data == e, "R11 rx word", 32'(rx_data), 32'(e));
      end
    end
  end

  task automatic push_tx(input logic [7:0] d);
    while (tx_full) @(negedge clk);
    tx_push = 1'b1;
    tx_data = d;
    tx_q.push_back(d & msk(slv_len));
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic send_cmd(input logic [1:0] cs, input logic cont, input logic contc, input logic [2:0] len);
    cmd_valid = 1'b1; cmd_cs = cs; cmd_cont = cont; cmd_contc = contc; cmd_len = len;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || !tx_empty);
    wait_clks(6);
  endtask

  task automatic wait_rx(input int n);
    while (rx_got < n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 0);
    finish_run();
  end

  initial begin
    int p, b;
    wait_clks(3);
    // R1 reset state
    chk(cs_n == 4'hF, "R1 cs", 32'(cs_n), 32'hF);
    chk(sck == 1'b1, "R1 sck", 32'(sck), 1);
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(tx_empty && rx_empty && !tx_full && !rx_full, "R1 fifo flags",
        32'({tx_empty, rx_empty, tx_full, rx_full}), 32'b1100);
    rst_n = 1'b1;
    wait_clks(2);

    // R3 per-frame select pulses, index 1
    p = pulses; b = rx_got;
    send_cmd(2'd1, 1'b0, 1'b0, 3'd7);
    push_tx(8'hC3); push_tx(8'h18); push_tx(8'hF0);
    wait (busy == 1'b1);
    @(negedge clk);
    chk(cs_n == 4'b1101, "R10 index 1", 32'(cs_n), 32'hD);
    wait_idle();
    chk(pulses == p + 3, "R3 pulse count", 32'(pulses - p), 3);
    chk(rx_got == b + 3, "R3 rx count", 32'(rx_got - b), 3);

    // R4/R5/R6/R7 20-frame continuous burst on index 2
    p = pulses; b = rx_got;
    send_cmd(2'd2, 1'b1, 1'b1, 3'd7);
    for (int i = 0; i < 20; i++) push_tx(8'(i * 13 + 1));
    chk(cs_n == 4'b1011, "R10 index 2", 32'(cs_n), 32'hB);
    wait_rx(b + 19);
    wait_clks(60);
    chk(sck == 1'b0, "R5 held sck", 32'(sck), 0);
    chk(busy == 1'b1, "R13 busy while held", 32'(busy), 1);
    chk(cs_n == 4'b1011, "R5 select held", 32'(cs_n), 32'hB);
    chk(rx_got == b + 19 && rx_empty, "R5 frame withheld", 32'(rx_got - b), 19);
    chk(pulses == p + 1, "R4 one pulse", 32'(pulses - p), 1);
    send_cmd(2'd2, 1'b1, 1'b1, 3'd7);
    wait_clks(40);
    chk(sck == 1'b0 && busy == 1'b1, "R6 still held", 32'({sck, busy}), 32'b01);
    chk(rx_got == b + 19, "R6 no push", 32'(rx_got - b), 19);
    send_cmd(2'd2, 1'b0, 1'b0, 3'd7);
    wait_idle();
    chk(rx_got == b + 20, "R7/R4 twenty entries", 32'(rx_got - b), 20);
    chk(cs_n == 4'hF && !busy, "R7 released", 32'(cs_n), 32'hF);
    chk(pulses == p + 1, "R4 single pulse", 32'(pulses - p), 1);

    // R8 new data while held continues the burst
    p = pulses; b = rx_got;
    send_cmd(2'd0, 1'b1, 1'b1, 3'd7);
    push_tx(8'h11); push_tx(8'h22);
    wait_rx(b + 1);
    wait_clks(60);
    chk(sck == 1'b0 && rx_got == b + 1, "R8 parked", 32'(rx_got - b), 1);
    push_tx(8'h33);
    wait_clks(100);
    chk(rx_got == b + 2, "R8 held frame pushed", 32'(rx_got - b), 2);
    chk(pulses == p + 1 && busy, "R8 no deselect", 32'(pulses - p), 1);
    chk(sck == 1'b0, "R8 parked again", 32'(sck), 0);
    send_cmd(2'd0, 1'b1, 1'b0, 3'd7);
    wait_idle();
    chk(rx_got == b + 3, "R7 contc clear ends", 32'(rx_got - b), 3);

    // R9 terminate and push in the same cycle
    p = pulses; b = rx_got;
    send_cmd(2'd3, 1'b1, 1'b1, 3'd7);
    push_tx(8'h81);
    wait_clks(80);
    chk(sck == 1'b0 && cs_n == 4'b0111, "R9 held on index 3", 32'(cs_n), 32'h7);
    cmd_valid = 1'b1; cmd_cs = 2'd1; cmd_cont = 1'b0; cmd_contc = 1'b0; cmd_len = 3'd7;
    tx_push = 1'b1; tx_data = 8'h42; tx_q.push_back(8'h42);
    @(negedge clk);
    cmd_valid = 1'b0; tx_push = 1'b0;
    wait (busy == 1'b0);
    chk(rx_got == b + 1, "R9 held frame first", 32'(rx_got - b), 1);
    wait (busy == 1'b1);
    @(negedge clk);
    chk(cs_n == 4'b1101, "R9 new index", 32'(cs_n), 32'hD);
    wait_idle();
    chk(pulses == p + 2 && rx_got == b + 2, "R9 two pulses", 32'(pulses - p), 2);

    // R11 4-bit frames
    b = rx_got;
    slv_len = 4;
    send_cmd(2'd0, 1'b0, 1'b0, 3'd3);
    push_tx(8'hA7); push_tx(8'h3C);
    wait_idle();
    chk(rx_got == b + 2, "R11 short frames", 32'(rx_got - b), 2);
    slv_len = 8;

    // R12/R14 rx full stall
    b = rx_got;
    auto_pop = 1'b0;
    send_cmd(2'd0, 1'b0, 1'b0, 3'd7);
    for (int i = 0; i < 5; i++) push_tx(8'(8'h90 + i));
    chk(tx_full == 1'b1, "R14 tx full at 4", 32'(tx_full), 1);
    wait_clks(400);
    chk(rx_full == 1'b1, "R14 rx full", 32'(rx_full), 1);
    chk(busy && sck == 1'b0, "R12 stalled before last edge", 32'({busy, sck}), 32'b10);
    chk(tx_empty == 1'b1, "R12 tx drained", 32'(tx_empty), 1);
    auto_pop = 1'b1;
    wait_idle();
    chk(rx_got == b + 5, "R12 resumed", 32'(rx_got - b), 5);
    chk(tx_q.size() == 0 && rx_q.size() == 0, "R4 scoreboard empty",
        32'(tx_q.size() + rx_q.size()), 0);
    finish_run();
  end
endmodule